// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block holds the pending-request vector for a group of interrupt lines. Each line is sampled synchronously on every clock. A per-line trigger-mode bit decides the behaviour. A level-sensitive line's pending bit tracks the input. An edge-sensitive line's pending bit is set by a low-to-high transition and stays set until it is acknowledged. Edge and level lines can be mixed freely because each line keeps its own record of the last sampled level.

The surrounding controller does three things with this block. It writes the trigger-mode register, whose writable bits are limited by a per-instance constant. It writes the mask register. It acknowledges one line at a time by index. Each time a pending bit goes from clear to set, the block reports one single-cycle event. That event appears on `raise_new` for an unmasked line, or on `raise_masked` for a masked line. A masked line still latches its request. A synchronous controller reset clears every line's history, drops edge-sensitive pending bits, keeps level-sensitive pending bits and clears the mask register.

Each line's history is a two-state machine. The states are HIST_LOW and HIST_HIGH. The transition RISE (HIST_LOW to HIST_HIGH) is taken when the line is sampled high in HIST_LOW, and it is the event that lets an edge line request. The transition FALL (HIST_HIGH to HIST_LOW) is taken when the line is sampled low. The transition FLUSH (any state to HIST_LOW) is taken on controller reset and has priority over RISE and FALL.

Top module: `irq_req_latch`

## Requirements
- R1: While asynchronous reset `rst_n` is low, `pend`, `raise_new`, `raise_masked`, `tmode` and `mask` are all zero, and every history is HIST_LOW.
- R2: A line whose `tmode` bit is 1 (level) has its `pend` bit equal, one clock later, to the `line_in` value sampled at that edge. This holds except on a controller-reset cycle.
- R3: A line whose `tmode` bit is 0 (edge) sets `pend` one clock after it is sampled high while its history is HIST_LOW. A low input never clears that `pend` bit.
- R4: When a `pend` bit goes from 0 to 1, the matching bit of `raise_new` (if that line's `mask` bit is 0) or of `raise_masked` (if its `mask` bit is 1) is 1 for exactly that one cycle. A request on a line whose `pend` bit is already set gives no event.
- R5: With `ack_valid` high, `ack_idx` (a binary line number) clears the `pend` bit of that line if it is an edge line. A level line is not affected. A new rising edge on the same line in the same cycle wins, and `pend` stays set.
- R6: A write on `tmode_we` stores `tmode_wdata & WMASK`. WMASK is 8'hF8 for a primary instance and 8'hDE for a secondary instance. Bits outside WMASK read 0.
- R7: On a cycle with `ctl_reset` high, the block does the following at the next edge: every history goes to HIST_LOW, edge-line `pend` bits clear, level-line `pend` bits keep their value, and `mask` clears. In that cycle `line_in` and `ack_valid` are ignored and no event is reported. `tmode` keeps its value, or takes a same-cycle write.
- R8: A write on `mask_we` stores `mask_wdata`, where 1 means masked. Masking changes only which event output reports a request; it does not change `pend`.
- R9: An edge line held high across a controller reset raises a fresh request on the first cycle after it, because its history was flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N | Raw request line levels, synchronous |
| tmode_we | input | 1 | Trigger-mode register write strobe |
| tmode_wdata | input | N | Trigger-mode write data (1 = level) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | N | Mask write data (1 = masked) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | $clog2(N) | Line number being acknowledged |
| ctl_reset | input | 1 | Synchronous controller reset |
| pend | output | N | Pending request vector |
| raise_new | output | N | One-cycle event: unmasked line became pending |
| raise_masked | output | N | One-cycle event: masked line became pending |
| tmode | output | N | Current trigger-mode register |
| mask | output | N | Current mask register |

## Verification
The acknowledge of an edge line and a new rising edge on that same line can fall in one cycle. The rule is that the set wins and no event is reported, because the bit was already pending. The bench provokes this directly: it holds an edge line pending, drops the line, and then raises it again in the same cycle as an acknowledge of that index. The random phase also hits the collision often, because it acknowledges random indices while it toggles lines. Every outcome is judged cycle by cycle against the bench's own model of pending bits, histories and event outputs. A controller reset that coincides with an acknowledge or a rising edge is covered the same way.

// File: rtl/irql_pkg.sv
package irql_pkg;
    // Per-line history of the last sampled level
    typedef enum logic {
        HIST_LOW  = 1'b0,
        HIST_HIGH = 1'b1
    } hist_e;

    // Trigger-mode encoding of one tmode bit
    localparam logic TRIG_EDGE  = 1'b0;
    localparam logic TRIG_LEVEL = 1'b1;
endpackage

// File: rtl/irql_line_cell.sv
module irql_line_cell
    import irql_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_lvl,
    input  logic trig,
    input  logic is_masked,
    input  logic ack_hit,
    input  logic ctl_reset,
    output logic pend,
    output logic raise_new,
    output logic raise_masked
);
    hist_e hist_q, hist_d;
    logic  pend_q, pend_d;
    logic  set_evt, new_req;
    logic  rn_q, rm_q;

    // History state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= HIST_LOW;
        else        hist_q <= hist_d;
    end

    // History transitions: RISE, FALL, FLUSH
    always_comb begin
        hist_d = hist_q;
        if (ctl_reset) begin
            hist_d = HIST_LOW;
        end else begin
            unique case (hist_q)
                HIST_LOW:  if (line_lvl)  hist_d = HIST_HIGH;
                HIST_HIGH: if (!line_lvl) hist_d = HIST_LOW;
                default:   hist_d = HIST_LOW;
            endcase
        end
    end

    // Pending bit and request event
    always_comb begin
        set_evt = 1'b0;
        pend_d  = pend_q;
        if (ctl_reset) begin
            pend_d = pend_q & (trig == TRIG_LEVEL);
        end else if (trig == TRIG_LEVEL) begin
            set_evt = line_lvl;
            pend_d  = line_lvl;
        end else begin
            set_evt = (hist_q == HIST_LOW) && line_lvl;
            pend_d  = set_evt | (pend_q & ~ack_hit);
        end
        new_req = set_evt & ~pend_q;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rn_q   <= 1'b0;
            rm_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            rn_q   <= new_req & ~is_masked;
            rm_q   <= new_req & is_masked;
        end
    end

    assign pend         = pend_q;
    assign raise_new    = rn_q;
    assign raise_masked = rm_q;
endmodule

// File: rtl/irql_cfg_regs.sv
module irql_cfg_regs #(
    parameter int           N     = 8,
    parameter logic [N-1:0] WMASK = 8'hF8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmode_we,
    input  logic [N-1:0] tmode_wdata,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         ctl_reset,
    output logic [N-1:0] tmode,
    output logic [N-1:0] mask
);
    logic [N-1:0] tmode_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmode_q <= '0;
            mask_q  <= '0;
        end else begin
            if (tmode_we) tmode_q <= tmode_wdata & WMASK;
            if (ctl_reset)    mask_q <= '0;
            else if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign tmode = tmode_q;
    assign mask  = mask_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int           N     = 8,
    parameter logic [N-1:0] WMASK = 8'hF8,
    localparam int          IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     line_in,
    input  logic             tmode_we,
    input  logic [N-1:0]     tmode_wdata,
    input  logic             mask_we,
    input  logic [N-1:0]     mask_wdata,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             ctl_reset,
    output logic [N-1:0]     pend,
    output logic [N-1:0]     raise_new,
    output logic [N-1:0]     raise_masked,
    output logic [N-1:0]     tmode,
    output logic [N-1:0]     mask
);
    logic [N-1:0] ack_hit;

    irql_cfg_regs #(.N(N), .WMASK(WMASK)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmode_we    (tmode_we),
        .tmode_wdata (tmode_wdata),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .ctl_reset   (ctl_reset),
        .tmode       (tmode),
        .mask        (mask)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        assign ack_hit[i] = ack_valid && (ack_idx == IDX_W'(i));

        irql_line_cell u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .line_lvl     (line_in[i]),
            .trig         (tmode[i]),
            .is_masked    (mask[i]),
            .ack_hit      (ack_hit[i]),
            .ctl_reset    (ctl_reset),
            .pend         (pend[i]),
            .raise_new    (raise_new[i]),
            .raise_masked (raise_masked[i])
        );
    end
endmodule

// File: rtl/irql_chk.sv
module irql_chk #(
    parameter int           N     = 8,
    parameter logic [N-1:0] WMASK = 8'hF8,
    localparam int          IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     line_in,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_idx,
    input logic             ctl_reset,
    input logic [N-1:0]     pend,
    input logic [N-1:0]     raise_new,
    input logic [N-1:0]     raise_masked,
    input logic [N-1:0]     tmode,
    input logic [N-1:0]     mask
);
    logic         past_ok;
    logic [N-1:0] ack_vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            ack_vec_q <= '0;
        end else begin
            past_ok   <= 1'b1;
            ack_vec_q <= ack_valid ? (N'(1) << ack_idx) : '0;
        end
    end

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ctl_reset)) |->
        ((pend & $past(tmode)) == ($past(line_in) & $past(tmode))));

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ctl_reset)) |->
        (($past(pend) & ~$past(tmode) & ~pend & ~ack_vec_q) == '0));

    // R4
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raise_new & raise_masked) == '0) && (((raise_new | raise_masked) & ~pend) == '0));

    // R4
    event_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((raise_new | raise_masked) & $past(pend)) == '0));

    // R6
    tmode_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmode & ~WMASK) == '0);

    // R7
    ctl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl_reset)) |->
        (mask == '0 && raise_new == '0 && raise_masked == '0 &&
         (pend & ~$past(tmode)) == '0));
endmodule

bind irq_req_latch irql_chk #(.N(N), .WMASK(WMASK)) u_irql_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_in      (line_in),
    .ack_valid    (ack_valid),
    .ack_idx      (ack_idx),
    .ctl_reset    (ctl_reset),
    .pend         (pend),
    .raise_new    (raise_new),
    .raise_masked (raise_masked),
    .tmode        (tmode),
    .mask         (mask)
);

// File: tb/test_irq_req_latch.sv
module test_irq_req_latch;
    localparam int       N   = 8;
    localparam logic [7:0] WM  = 8'hF8;
    localparam logic [7:0] WM2 = 8'hDE;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] line_in, tmode_wdata, mask_wdata;
    logic       tmode_we, mask_we, ack_valid, ctl_reset;
    logic [2:0] ack_idx;
    logic [7:0] pend, raise_new, raise_masked, tmode, mask;
    logic [7:0] pend2, rn2, rm2, tmode2, mask2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] e_pend, e_rn, e_rm, e_tm, e_mask, e_hist;

    always #5 clk = ~clk;

    irq_req_latch i_irq_req_latch (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .tmode_we(tmode_we), .tmode_wdata(tmode_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .ctl_reset(ctl_reset),
        .pend(pend), .raise_new(raise_new), .raise_masked(raise_masked),
        .tmode(tmode), .mask(mask)
    );

    irq_req_latch #(.N(8), .WMASK(WM2)) i_irq_req_latch_sec (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .tmode_we(tmode_we), .tmode_wdata(tmode_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .ctl_reset(ctl_reset),
        .pend(pend2), .raise_new(rn2), .raise_masked(rm2),
        .tmode(tmode2), .mask(mask2)
    );

    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %02h expected %02h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "pend", pend, e_pend);
        chk(tag, "raise_new", raise_new, e_rn);
        chk(tag, "raise_masked", raise_masked, e_rm);
        chk(tag, "tmode", tmode, e_tm);
        chk(tag, "mask", mask, e_mask);
    endtask

    // Expected state after the coming clock edge, from the requirements
    task automatic model_step();
        logic [7:0] np, nrn, nrm, nh;
        np = e_pend; nrn = '0; nrm = '0; nh = e_hist;
        if (ctl_reset) begin
            nh = '0;
            np = e_pend & e_tm;
        end else begin
            for (int i = 0; i < 8; i++) begin
                logic setv;
                if (e_tm[i]) begin
                    setv  = line_in[i];
                    np[i] = line_in[i];
                end else begin
                    setv  = line_in[i] && !e_hist[i];
                    if (ack_valid && ack_idx == 3'(i)) np[i] = 1'b0;
                    if (setv) np[i] = 1'b1;
                end
                if (setv && !e_pend[i]) begin
                    if (e_mask[i]) nrm[i] = 1'b1;
                    else           nrn[i] = 1'b1;
                end
                nh[i] = line_in[i];
            end
        end
        e_pend = np; e_rn = nrn; e_rm = nrm; e_hist = nh;
        if (tmode_we) e_tm = tmode_wdata & WM;
        if (ctl_reset)    e_mask = '0;
        else if (mask_we) e_mask = mask_wdata;
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        check_all(tag);
        tmode_we = 0; mask_we = 0; ack_valid = 0; ctl_reset = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd12345;
        void'($urandom(seed));
        rst_n = 0; line_in = 8'hFF; tmode_we = 0; tmode_wdata = 8'hFF;
        mask_we = 0; mask_wdata = 8'hFF; ack_valid = 0; ack_idx = 0; ctl_reset = 0;
        e_pend = 0; e_rn = 0; e_rm = 0; e_tm = 0; e_mask = 0; e_hist = 0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        line_in = 0;
        @(negedge clk);
        rst_n = 1;
        step("R1 after release");

        // R6: writable-bit mask for both instances
        tmode_we = 1; tmode_wdata = 8'hFF;
        step("R6 tmode write FF");
        chk("R6 secondary", "tmode", tmode2, WM2);
        tmode_we = 1; tmode_wdata = 8'hF0;   // lines 4..7 level, 0..3 edge
        step("R6 tmode write F0");

        // R3 edge line 3: rise, hold, drop
        line_in = 8'h08; step("R3 R4 edge rise");
        step("R3 edge hold high");
        line_in = 8'h00; step("R3 low keeps pend");
        // R2 level line 5
        line_in = 8'h20; step("R2 R4 level rise");
        line_in = 8'h00; step("R2 level drop");
        // R5 acknowledge edge line 3 and level line 6
        line_in = 8'h40; step("R2 level rise 6");
        ack_valid = 1; ack_idx = 3'd6; step("R5 ack level no effect");
        ack_valid = 1; ack_idx = 3'd3; step("R5 ack edge clears");
        // R5 collision: pend edge line 3 again, ack plus new rise same cycle
        line_in = 8'h48; step("R3 edge rise again");
        line_in = 8'h40; step("R3 drop");
        line_in = 8'h48; ack_valid = 1; ack_idx = 3'd3; step("R5 ack and rise collide");
        // R8 masked lines still latch
        mask_we = 1; mask_wdata = 8'h82; step("R8 mask write");
        line_in = 8'hCA; step("R8 R4 masked raise");
        // R7 controller reset, R9 held edge line re-requests
        ack_valid = 1; ack_idx = 3'd1; ctl_reset = 1; step("R7 ctl reset");
        step("R9 held edge re-requests");
        line_in = 8'h00; step("R2 drop all");

        for (int k = 0; k < 4000; k++) begin
            line_in = 8'($urandom());
            if ($urandom_range(0, 15) == 0) begin
                tmode_we = 1; tmode_wdata = 8'($urandom());
            end
            if ($urandom_range(0, 15) == 0) begin
                mask_we = 1; mask_wdata = 8'($urandom());
            end
            ack_valid = ($urandom_range(0, 2) == 0);
            ack_idx   = 3'($urandom());
            ctl_reset = ($urandom_range(0, 63) == 0);
            step("rand R2 R3 R4 R5 R7 R8");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule